// File: doc/BRIEF.md
# Processor Mode Controller

This block keeps track of a processor's privilege and addressing state. The state has two dimensions. Addressing is either absolute or appending. Within appending, execution is either master (privileged) or slave (user). Absolute mode always executes with full privilege.

For each completed instruction, the surrounding pipeline presents decoded attributes:
- whether the instruction is privileged;
- whether it asks to inhibit interrupts;
- whether it is a transfer;
- whether its operand address was formed by the appending process;
- a target privilege bit.

The controller checks these attributes against the current mode. It raises an illegal-procedure fault when slave mode forbids the request, and reports whether the instruction may commit its side effects.

Faults and interrupts force absolute mode. The only way back to appending mode is an appended transfer. The controller also presents the effective address clipped to the absolute-mode width while absolute mode is in force.

All outputs are registered. An instruction presented in one cycle shows its results, including any mode change, after the next rising clock edge.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst` is sampled high, the outputs are set as follows after the edge: `mode_o` = 2'b00 (absolute), `inh_o` = 1, `illegal_o` = 0, `commit_o` = 0 and `addr_wide_o` = 0.
- R2: A valid privileged instruction in append-slave mode (`mode_o` = 2'b11) has three effects after the edge: `illegal_o` = 1, `commit_o` = 0 and `mode_o` = 2'b00, all in that same cycle.
- R3: A valid instruction that requests interrupt inhibit in append-slave mode raises `illegal_o` and clears `commit_o`. It leaves `inh_o` unchanged.
- R4: In absolute mode (2'b00) or append-master mode (2'b10), every valid instruction is legal. After the edge, `commit_o` = 1 and `illegal_o` = 0, and `inh_o` takes the instruction's inhibit request.
- R5: When `fault_in` or `intr_in` is high, `mode_o` is 2'b00 after the edge, regardless of the instruction.
- R6: In absolute mode, a valid transfer whose operand was appended, with no fault or interrupt present, enters appending mode. The mode becomes append-master (2'b10) when `tgt_master_i` = 1 and append-slave (2'b11) otherwise.
- R7: In absolute mode, any cycle that lacks a valid appended transfer leaves the mode absolute.
- R8: In appending mode, the master/slave choice never changes. The mode either stays the same or drops to absolute; appended transfers here ignore `tgt_master_i`.
- R9: `addr_o` is `addr_i` registered, using the mode in force when `addr_i` was presented:
  - in absolute mode, bits above the low 18 (`ABS_W`) are zeroed and `addr_wide_o` = 0;
  - in appending mode, all 24 (`VA_W`) bits pass and `addr_wide_o` = 1.
- R10: When a fault or interrupt coincides with an appended transfer in absolute mode, absolute mode is kept. The legal transfer still reports `commit_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | An instruction completes this cycle |
| instr_priv_i | input | 1 | Instruction is privileged |
| instr_inh_i | input | 1 | Instruction requests interrupt inhibit |
| instr_xfer_i | input | 1 | Instruction is a transfer |
| instr_appended_i | input | 1 | Operand address formed by appending |
| tgt_master_i | input | 1 | Target privilege when leaving absolute mode (1 = master) |
| fault_in | input | 1 | Fault event |
| intr_in | input | 1 | Interrupt event |
| addr_i | input | VA_W | Effective address of the current access |
| mode_o | output | 2 | 00 absolute, 10 append-master, 11 append-slave |
| illegal_o | output | 1 | Illegal-procedure fault for the previous instruction |
| commit_o | output | 1 | Previous instruction may commit its side effects |
| inh_o | output | 1 | Interrupt inhibit in force |
| addr_wide_o | output | 1 | Full-width addressing selected |
| addr_o | output | VA_W | Width-limited address |

## Verification
A fault or interrupt can arrive in the same cycle as the appended transfer that would leave absolute mode. The same contention exists between an external event and an illegal instruction in slave mode. The bench provokes both with directed steps, and its random stimulus lets them recur.

In each case the bench judges the result from a bench-side model. The event must win on the mode, so the mode stays or becomes absolute. The instruction's own legality verdict (`commit_o` or `illegal_o`) must still be reported independently.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  typedef enum logic [1:0] {
    PM_ABS   = 2'b00,
    PM_APP_M = 2'b10,
    PM_APP_S = 2'b11
  } pmode_e;

  typedef struct packed {
    logic valid;
    logic priv;
    logic inh;
    logic xfer;
    logic appended;
    logic tgt_master;
  } instr_t;

endpackage

// File: rtl/pmode_check.sv
module pmode_check
  import pmode_pkg::*;
(
  input  pmode_e mode,
  input  instr_t ins,
  output logic   illegal,
  output logic   grant,
  output logic   inh_take
);
  logic slave;
  logic forbidden;

  always_comb begin
    slave     = (mode == PM_APP_S);
    forbidden = slave && (ins.priv || ins.inh);
    illegal   = ins.valid && forbidden;
    grant     = ins.valid && !forbidden;
    inh_take  = grant;
  end
endmodule

// File: rtl/pmode_state.sv
module pmode_state
  import pmode_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  instr_t ins,
  input  logic   event_hit,
  input  logic   illegal,
  input  logic   inh_take,
  output pmode_e mode_q,
  output logic   inh_q
);
  pmode_e mode_d;
  logic   exit_req;

  always_comb begin
    exit_req = ins.valid && ins.xfer && ins.appended;
    mode_d   = mode_q;
    if (event_hit || illegal) begin
      mode_d = PM_ABS;
    end else begin
      case (mode_q)
        PM_ABS:   mode_d = exit_req ? (ins.tgt_master ? PM_APP_M : PM_APP_S) : PM_ABS;
        PM_APP_M: mode_d = PM_APP_M;
        PM_APP_S: mode_d = PM_APP_S;
        default:  mode_d = PM_ABS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_ABS;
      inh_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      if (inh_take) inh_q <= ins.inh;
    end
  end
endmodule

// File: rtl/pmode_addr.sv
module pmode_addr #(
  parameter int VA_W  = 24,
  parameter int ABS_W = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide,
  input  logic [VA_W-1:0] addr_in,
  output logic [VA_W-1:0] addr_q,
  output logic            wide_q
);
  logic [VA_W-1:0] addr_d;

  generate
    if (ABS_W >= VA_W) begin : g_no_clip
      assign addr_d = addr_in;
    end else begin : g_clip
      localparam int HI_W = VA_W - ABS_W;
      assign addr_d = wide ? addr_in : {{HI_W{1'b0}}, addr_in[ABS_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wide_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      wide_q <= wide;
    end
  end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int VA_W  = 24,
  parameter int ABS_W = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid_i,
  input  logic            instr_priv_i,
  input  logic            instr_inh_i,
  input  logic            instr_xfer_i,
  input  logic            instr_appended_i,
  input  logic            tgt_master_i,
  input  logic            fault_in,
  input  logic            intr_in,
  input  logic [VA_W-1:0] addr_i,
  output logic [1:0]      mode_o,
  output logic            illegal_o,
  output logic            commit_o,
  output logic            inh_o,
  output logic            addr_wide_o,
  output logic [VA_W-1:0] addr_o
);
  instr_t ins;
  pmode_e mode_q;
  logic   illegal, grant, inh_take, event_hit;

  assign ins = '{valid: instr_valid_i, priv: instr_priv_i, inh: instr_inh_i,
                 xfer: instr_xfer_i, appended: instr_appended_i,
                 tgt_master: tgt_master_i};
  assign event_hit = fault_in || intr_in;

  pmode_check u_check (
    .mode     (mode_q),
    .ins      (ins),
    .illegal  (illegal),
    .grant    (grant),
    .inh_take (inh_take)
  );

  pmode_state u_state (
    .clk       (clk),
    .rst       (rst),
    .ins       (ins),
    .event_hit (event_hit),
    .illegal   (illegal),
    .inh_take  (inh_take),
    .mode_q    (mode_q),
    .inh_q     (inh_o)
  );

  pmode_addr #(.VA_W(VA_W), .ABS_W(ABS_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .wide    (mode_q != PM_ABS),
    .addr_in (addr_i),
    .addr_q  (addr_o),
    .wide_q  (addr_wide_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_o <= 1'b0;
      commit_o  <= 1'b0;
    end else begin
      illegal_o <= illegal;
      commit_o  <= grant;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pmode_ctrl_sva.sv
module pmode_ctrl_sva #(
  parameter int VA_W  = 24,
  parameter int ABS_W = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            instr_valid_i,
  input logic            instr_priv_i,
  input logic            instr_inh_i,
  input logic            instr_xfer_i,
  input logic            instr_appended_i,
  input logic            fault_in,
  input logic            intr_in,
  input logic [1:0]      mode_o,
  input logic            illegal_o,
  input logic            commit_o,
  input logic            inh_o,
  input logic            addr_wide_o,
  input logic [VA_W-1:0] addr_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mode_o == 2'b00 && inh_o && !illegal_o && !commit_o && !addr_wide_o));

  a_r2_slave_priv: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && instr_priv_i && mode_o == 2'b11)
      |=> (illegal_o && !commit_o && mode_o == 2'b00));

  a_r3_slave_inh: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && instr_inh_i && mode_o == 2'b11)
      |=> (illegal_o && $stable(inh_o)));

  a_r4_priv_ok: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && mode_o != 2'b11) |=> (commit_o && !illegal_o));

  a_r5_event_abs: assert property (@(posedge clk) disable iff (rst)
    (fault_in || intr_in) |=> (mode_o == 2'b00));

  a_r6_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && instr_valid_i && instr_xfer_i && instr_appended_i
     && !fault_in && !intr_in) |=> mode_o[1]);

  a_r7_stay_abs: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00 && !(instr_valid_i && instr_xfer_i && instr_appended_i))
      |=> (mode_o == 2'b00));

  a_r8_keep_priv: assert property (@(posedge clk) disable iff (rst)
    mode_o[1] |=> (mode_o == 2'b00 || $stable(mode_o)));

  a_r9_clip: assert property (@(posedge clk) disable iff (rst)
    !addr_wide_o |-> (addr_o[VA_W-1:ABS_W] == '0));

  a_r2_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({illegal_o, commit_o}));
endmodule

bind pmode_ctrl pmode_ctrl_sva #(.VA_W(VA_W), .ABS_W(ABS_W)) u_sva (.*);

// File: tb/pmode_ctrl_bench.sv
`timescale 1ns/1ps
module pmode_ctrl_bench;
  localparam int VA_W  = 24;
  localparam int ABS_W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v = 0, p = 0, ih = 0, x = 0, ap = 0, tm = 0, f = 0, q = 0;
  logic [VA_W-1:0] addr = '0;
  logic [1:0] mode_o;
  logic illegal_o, commit_o, inh_o, addr_wide_o;
  logic [VA_W-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_mode = 2'b00;
  logic m_inh = 1'b1;

  always #2 clk = ~clk;

  pmode_ctrl #(.VA_W(VA_W), .ABS_W(ABS_W)) u_pmode_ctrl (
    .clk(clk), .rst(rst), .instr_valid_i(v), .instr_priv_i(p), .instr_inh_i(ih),
    .instr_xfer_i(x), .instr_appended_i(ap), .tgt_master_i(tm), .fault_in(f),
    .intr_in(q), .addr_i(addr), .mode_o(mode_o), .illegal_o(illegal_o),
    .commit_o(commit_o), .inh_o(inh_o), .addr_wide_o(addr_wide_o), .addr_o(addr_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] clip(logic [1:0] md, logic [VA_W-1:0] a);
    logic [VA_W-1:0] lo_mask;
    lo_mask = (VA_W'(1) << ABS_W) - VA_W'(1);
    return (md == 2'b00) ? (a & lo_mask) : a;
  endfunction

  task automatic step(logic iv, logic ip, logic ii, logic ix, logic ia, logic it,
                      logic ifl, logic iq, logic [VA_W-1:0] ad);
    logic slave, ill, com, ev, exit_rq;
    logic [1:0] nm;
    logic [VA_W-1:0] ea;
    logic ew;
    string mtag, ctag, itag;
    v = iv; p = ip; ih = ii; x = ix; ap = ia; tm = it; f = ifl; q = iq; addr = ad;
    slave   = (m_mode == 2'b11);
    ill     = iv && slave && (ip || ii);
    com     = iv && !(slave && (ip || ii));
    ev      = ifl || iq;
    exit_rq = iv && ix && ia;
    ea      = clip(m_mode, ad);
    ew      = (m_mode != 2'b00);
    if (ev) begin
      nm = 2'b00;
      mtag = (m_mode == 2'b00 && exit_rq) ? "R10" : "R5";
    end else if (ill) begin
      nm = 2'b00; mtag = "R2";
    end else if (m_mode == 2'b00) begin
      nm = exit_rq ? (it ? 2'b10 : 2'b11) : 2'b00;
      mtag = exit_rq ? "R6" : "R7";
    end else begin
      nm = m_mode; mtag = "R8";
    end
    ctag = ill ? ((slave && ip) ? "R2" : "R3") : ((ev && exit_rq) ? "R10" : "R4");
    itag = (slave && ii) ? "R3" : "R4";
    if (com) m_inh = ii;
    m_mode = nm;
    @(posedge clk);
    #1;
    chk(mtag, "mode", 32'(mode_o), 32'(nm));
    chk(ctag, "illegal", 32'(illegal_o), 32'(ill));
    chk(ctag, "commit", 32'(commit_o), 32'(com));
    chk(itag, "inhibit", 32'(inh_o), 32'(m_inh));
    chk("R9", "addr", 32'(addr_o), 32'(ea));
    chk("R9", "wide", 32'(addr_wide_o), 32'(ew));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", "mode", 32'(mode_o), 32'd0);
    chk("R1", "inh", 32'(inh_o), 32'd1);
    chk("R1", "illegal", 32'(illegal_o), 32'd0);
    chk("R1", "commit", 32'(commit_o), 32'd0);
    chk("R1", "wide", 32'(addr_wide_o), 32'd0);
    rst = 1'b0;
    // directed corner cases
    step(1,0,0,1,1,0,0,0,24'hFFFFFF); // R6 exit to slave, address clipped
    step(1,1,0,0,0,0,0,0,24'hABCDEF); // R2 slave privileged
    step(1,0,0,1,0,1,0,0,24'h000123); // R7 unappended transfer stays absolute
    step(1,0,0,1,1,1,0,0,24'h800001); // R6 exit to master
    step(1,1,1,0,0,0,0,0,24'hFC0000); // R4 master privileged + inhibit, R9 wide
    step(1,0,0,1,1,0,0,0,24'h123456); // R8 transfer keeps master
    step(0,0,0,0,0,0,0,1,24'h7FFFFF); // R5 interrupt
    step(1,1,0,0,0,0,0,0,24'h040000); // R4 absolute privileged, inhibit off
    step(1,0,0,1,1,1,1,0,24'h3FFFF0); // R10 fault with exit
    step(1,0,0,1,1,0,0,0,24'h000000); // R6 exit to slave
    step(1,0,1,0,0,0,0,0,24'h111111); // R3 slave inhibit refused
    step(1,0,0,1,1,0,0,0,24'h000000); // R6 back to slave
    step(1,1,0,0,0,0,1,0,24'h222222); // R2 with fault same cycle
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
           ($urandom % 24) == 0, ($urandom % 24) == 0, VA_W'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule